// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block sits between a transmit buffer, a receive buffer and a byte-wide serial transmitter and receiver. It asks the far end to pause or resume by inserting in-band control characters into the outgoing byte stream. On the transmit side it takes user bytes from the transmit buffer over a valid/data/got handshake. When a control character is due, that character is sent ahead of the user byte. User bytes whose value equals either control code are consumed but never sent, so the far end cannot confuse them with flow commands.

On the receive side, every received byte is written into the receive buffer unless that buffer is full. A byte that arrives while the buffer is full sets a sticky overflow flag. The receive buffer reports its fill level as an N-bit quantized value. A pause character goes out once when the fill level climbs to the high threshold. A resume character goes out once when the fill level sits exactly on the low threshold. The block leaves reset in the paused state, so a resume character is announced as soon as the low-threshold condition is met.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: Reset clears the overflow flag and puts the block in the paused state. After reset, the first cycle with fill level equal to the resume threshold and the transmitter ready sends the resume code.
- R2: With N = FILL_BITS, the pause threshold is round(0.75·2^N) and the resume threshold is round(2^N/16), rounding halves up. N below 3 is rejected at elaboration. For the default N = 4 the thresholds are 12 and 1.
- R3: A pause code (default 0x13) is requested only while the block is not paused and the fill level is at or above the pause threshold. After it is accepted, no further pause code goes out until the block has been resumed.
- R4: The paused state is set on any cycle with the transmitter ready and the fill level at or above the pause threshold. It is cleared on any cycle with the transmitter ready and the fill level equal to the resume threshold.
- R5: A resume code (default 0x11) is requested only while paused and only when the fill level equals the resume threshold. Levels above or below that value do not trigger it.
- R6: A pending control code is sent before any user byte. While a control code is pending, the transmit buffer is not acknowledged.
- R7: A user byte equal to the pause or resume code is acknowledged to the transmit buffer (tb_got high) but is not strobed to the transmitter.
- R8: tb_got is high only when no control code is pending, tb_valid is high and ser_ready is high.
- R9: ser_stb is never high while ser_ready is low, so each byte is issued in exactly one accepted cycle.
- R10: rb_put equals des_stb while rb_full is low and is low while rb_full is high. rb_data carries des_data unchanged.
- R11: A des_stb while rb_full is high sets rx_overflow from the next cycle on. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_valid | input | 1 | Transmit buffer holds a byte |
| tb_data | input | 8 | Byte at the head of the transmit buffer |
| tb_got | output | 1 | Acknowledge: head byte consumed |
| ser_stb | output | 1 | Byte strobe to the transmitter |
| ser_data | output | 8 | Byte to the transmitter |
| ser_ready | input | 1 | Transmitter can accept a byte this cycle |
| des_stb | input | 1 | Receiver delivers a byte this cycle |
| des_data | input | 8 | Received byte |
| rb_put | output | 1 | Write strobe into the receive buffer |
| rb_data | output | 8 | Byte written into the receive buffer |
| rb_full | input | 1 | Receive buffer full |
| rb_fill | input | FILL_BITS | Quantized receive-buffer fill level |
| rx_overflow | output | 1 | Sticky receive overflow flag |

## Verification
The hardest situation to reach is a second crossing of the pause threshold. That needs the block to be paused, then resumed by landing exactly on the resume level with the transmitter ready, and only then pushed back above the pause level. The stimulus table walks the fill level through that full path in order. It holds the transmitter not-ready on the crossing cycles so the pending-but-unsent control code is also seen. Fill levels one step off each threshold are placed next to the exact values to expose off-by-one comparisons.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

    typedef enum logic [1:0] {
        SEL_USER = 2'd0,
        SEL_XON  = 2'd1,
        SEL_XOFF = 2'd2
    } tx_sel_e;

    typedef struct packed {
        logic want_xoff;
        logic want_xon;
    } ctl_req_t;

    // round(0.75 * 2^n), halves up
    function automatic int pause_level(input int n);
        return (3 * (1 << n) + 2) / 4;
    endfunction

    // round(2^n / 16), halves up
    function automatic int resume_level(input int n);
        return ((1 << n) + 8) / 16;
    endfunction

endpackage

// File: rtl/swfc_pause_ctrl.sv
module swfc_pause_ctrl
    import swfc_pkg::*;
#(
    parameter int FILL_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_ready,
    input  logic [FILL_BITS-1:0] fill,
    output ctl_req_t             req,
    output logic                 paused
);
    localparam logic [FILL_BITS-1:0] HI_LVL = FILL_BITS'(pause_level(FILL_BITS));
    localparam logic [FILL_BITS-1:0] LO_LVL = FILL_BITS'(resume_level(FILL_BITS));

    logic above_hi;
    logic at_lo;
    logic paused_q;

    assign above_hi = (fill >= HI_LVL);
    assign at_lo    = (fill == LO_LVL);

    always_ff @(posedge clk) begin
        if (rst) begin
            paused_q <= 1'b1;
        end else if (ser_ready && above_hi) begin
            paused_q <= 1'b1;
        end else if (ser_ready && at_lo) begin
            paused_q <= 1'b0;
        end
    end

    always_comb begin
        req.want_xoff = above_hi && !paused_q;
        req.want_xon  = at_lo && paused_q;
    end

    assign paused = paused_q;

endmodule

// File: rtl/swfc_tx_mux.sv
module swfc_tx_mux
    import swfc_pkg::*;
#(
    parameter logic [7:0] XON_CODE  = 8'h11,
    parameter logic [7:0] XOFF_CODE = 8'h13
) (
    input  ctl_req_t    req,
    input  logic        tb_valid,
    input  logic [7:0]  tb_data,
    input  logic        ser_ready,
    output logic        ser_stb,
    output logic [7:0]  ser_data,
    output logic        tb_got
);
    tx_sel_e sel;
    logic    user_is_ctl;
    logic    want_send;

    always_comb begin
        if (req.want_xoff) begin
            sel = SEL_XOFF;
        end else if (req.want_xon) begin
            sel = SEL_XON;
        end else begin
            sel = SEL_USER;
        end
    end

    assign user_is_ctl = (tb_data == XON_CODE) || (tb_data == XOFF_CODE);

    always_comb begin
        case (sel)
            SEL_XOFF: begin
                ser_data  = XOFF_CODE;
                want_send = 1'b1;
            end
            SEL_XON: begin
                ser_data  = XON_CODE;
                want_send = 1'b1;
            end
            default: begin
                ser_data  = tb_data;
                want_send = tb_valid && !user_is_ctl;
            end
        endcase
    end

    assign ser_stb = want_send && ser_ready;
    assign tb_got  = (sel == SEL_USER) && tb_valid && ser_ready;

endmodule

// File: rtl/swfc_rx_path.sv
module swfc_rx_path (
    input  logic       clk,
    input  logic       rst,
    input  logic       des_stb,
    input  logic [7:0] des_data,
    input  logic       rb_full,
    output logic       rb_put,
    output logic [7:0] rb_data,
    output logic       overflow
);
    logic ovf_q;

    assign rb_put  = des_stb && !rb_full;
    assign rb_data = des_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (des_stb && rb_full) begin
            ovf_q <= 1'b1;
        end
    end

    assign overflow = ovf_q;

endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
    import swfc_pkg::*;
#(
    parameter int         FILL_BITS = 4,
    parameter logic [7:0] XON_CODE  = 8'h11,
    parameter logic [7:0] XOFF_CODE = 8'h13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tb_valid,
    input  logic [7:0]           tb_data,
    output logic                 tb_got,
    output logic                 ser_stb,
    output logic [7:0]           ser_data,
    input  logic                 ser_ready,
    input  logic                 des_stb,
    input  logic [7:0]           des_data,
    output logic                 rb_put,
    output logic [7:0]           rb_data,
    input  logic                 rb_full,
    input  logic [FILL_BITS-1:0] rb_fill,
    output logic                 rx_overflow
);
    // R2: thresholds must be distinct and non-zero
    if (FILL_BITS < 3) begin : g_bad_fill_bits
        $error("xonxoff_flow_ctrl: FILL_BITS must be at least 3");
    end

    ctl_req_t ctl_req;
    logic     paused_q;

    swfc_pause_ctrl #(
        .FILL_BITS (FILL_BITS)
    ) u_pause (
        .clk       (clk),
        .rst       (rst),
        .ser_ready (ser_ready),
        .fill      (rb_fill),
        .req       (ctl_req),
        .paused    (paused_q)
    );

    swfc_tx_mux #(
        .XON_CODE  (XON_CODE),
        .XOFF_CODE (XOFF_CODE)
    ) u_txmux (
        .req       (ctl_req),
        .tb_valid  (tb_valid),
        .tb_data   (tb_data),
        .ser_ready (ser_ready),
        .ser_stb   (ser_stb),
        .ser_data  (ser_data),
        .tb_got    (tb_got)
    );

    swfc_rx_path u_rx (
        .clk      (clk),
        .rst      (rst),
        .des_stb  (des_stb),
        .des_data (des_data),
        .rb_full  (rb_full),
        .rb_put   (rb_put),
        .rb_data  (rb_data),
        .overflow (rx_overflow)
    );

endmodule

// File: rtl/swfc_chk.sv
module swfc_chk
    import swfc_pkg::*;
#(
    parameter int         FILL_BITS = 4,
    parameter logic [7:0] XON_CODE  = 8'h11,
    parameter logic [7:0] XOFF_CODE = 8'h13
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tb_valid,
    input logic [7:0]           tb_data,
    input logic                 tb_got,
    input logic                 ser_stb,
    input logic [7:0]           ser_data,
    input logic                 ser_ready,
    input logic                 des_stb,
    input logic                 rb_put,
    input logic                 rb_full,
    input logic [FILL_BITS-1:0] rb_fill,
    input logic                 rx_overflow,
    input logic                 paused_q
);
    localparam int HI = pause_level(FILL_BITS);
    localparam int LO = resume_level(FILL_BITS);

    logic xoff_out;
    logic xon_out;
    assign xoff_out = ser_stb && (ser_data == XOFF_CODE);
    assign xon_out  = ser_stb && (ser_data == XON_CODE);

    // R9
    stb_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ser_stb |-> ser_ready);

    // R8
    got_conditions_chk: assert property (@(posedge clk) disable iff (rst)
        tb_got |-> (tb_valid && ser_ready && !xoff_out && !xon_out));

    // R3
    xoff_cause_chk: assert property (@(posedge clk) disable iff (rst)
        xoff_out |-> (!paused_q && (int'(rb_fill) >= HI)));

    // R3
    xoff_once_chk: assert property (@(posedge clk) disable iff (rst)
        xoff_out |=> !xoff_out);

    // R5
    xon_cause_chk: assert property (@(posedge clk) disable iff (rst)
        xon_out |-> (paused_q && (int'(rb_fill) == LO)));

    // R4
    pause_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_ready && (int'(rb_fill) >= HI)) |=> paused_q);

    // R4
    pause_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_ready && (int'(rb_fill) == LO)) |=> !paused_q);

    // R7
    ctl_user_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (tb_got && ((tb_data == XON_CODE) || (tb_data == XOFF_CODE))) |-> !ser_stb);

    // R10
    put_gate_chk: assert property (@(posedge clk) disable iff (rst)
        rb_put |-> (des_stb && !rb_full));

    // R11
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (des_stb && rb_full) |=> rx_overflow);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rx_overflow |=> rx_overflow);

endmodule

bind xonxoff_flow_ctrl swfc_chk #(
    .FILL_BITS (FILL_BITS),
    .XON_CODE  (XON_CODE),
    .XOFF_CODE (XOFF_CODE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tb_valid    (tb_valid),
    .tb_data     (tb_data),
    .tb_got      (tb_got),
    .ser_stb     (ser_stb),
    .ser_data    (ser_data),
    .ser_ready   (ser_ready),
    .des_stb     (des_stb),
    .rb_put      (rb_put),
    .rb_full     (rb_full),
    .rb_fill     (rb_fill),
    .rx_overflow (rx_overflow),
    .paused_q    (paused_q)
);

// File: tb/sim_xonxoff_flow_ctrl.sv
module sim_xonxoff_flow_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       tb_valid;
    logic [7:0] tb_data;
    logic       tb_got;
    logic       ser_stb;
    logic [7:0] ser_data;
    logic       ser_ready;
    logic       des_stb;
    logic [7:0] des_data;
    logic       rb_put;
    logic [7:0] rb_data;
    logic       rb_full;
    logic [3:0] rb_fill;
    logic       rx_overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    xonxoff_flow_ctrl u0 (
        .clk(clk), .rst(rst),
        .tb_valid(tb_valid), .tb_data(tb_data), .tb_got(tb_got),
        .ser_stb(ser_stb), .ser_data(ser_data), .ser_ready(ser_ready),
        .des_stb(des_stb), .des_data(des_data),
        .rb_put(rb_put), .rb_data(rb_data), .rb_full(rb_full),
        .rb_fill(rb_fill), .rx_overflow(rx_overflow)
    );

    // vector: {req, fill, valid, data, ready, exp_stb, exp_data, exp_got}
    typedef struct packed {
        logic [3:0] req;
        logic [3:0] fill;
        logic       valid;
        logic [7:0] data;
        logic       ready;
        logic       e_stb;
        logic [7:0] e_data;
        logic       e_got;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        '{4'd8,  4'd0,  1'b1, 8'h41, 1'b1, 1'b1, 8'h41, 1'b1}, // R8 plain byte while paused
        '{4'd9,  4'd1,  1'b1, 8'h42, 1'b0, 1'b0, 8'h11, 1'b0}, // R9 XON pending, not ready
        '{4'd1,  4'd1,  1'b1, 8'h42, 1'b1, 1'b1, 8'h11, 1'b0}, // R1 XON after reset, R6
        '{4'd4,  4'd1,  1'b1, 8'h42, 1'b1, 1'b1, 8'h42, 1'b1}, // R4 cleared, user byte
        '{4'd9,  4'd12, 1'b1, 8'h43, 1'b0, 1'b0, 8'h13, 1'b0}, // R9 XOFF pending, not ready
        '{4'd3,  4'd12, 1'b1, 8'h43, 1'b1, 1'b1, 8'h13, 1'b0}, // R3 XOFF at threshold, R6
        '{4'd3,  4'd13, 1'b1, 8'h43, 1'b1, 1'b1, 8'h43, 1'b1}, // R3 no second XOFF
        '{4'd7,  4'd5,  1'b1, 8'h13, 1'b1, 1'b0, 8'h13, 1'b1}, // R7 user XOFF dropped
        '{4'd7,  4'd5,  1'b1, 8'h11, 1'b1, 1'b0, 8'h11, 1'b1}, // R7 user XON dropped
        '{4'd8,  4'd5,  1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0}, // R8 no valid
        '{4'd5,  4'd1,  1'b0, 8'h00, 1'b1, 1'b1, 8'h11, 1'b0}, // R5 XON at resume level
        '{4'd5,  4'd1,  1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0}, // R5 only once
        '{4'd3,  4'd15, 1'b1, 8'h44, 1'b1, 1'b1, 8'h13, 1'b0}, // R3 second crossing, R6
        '{4'd3,  4'd15, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0}, // R3 once
        '{4'd4,  4'd11, 1'b1, 8'h45, 1'b1, 1'b1, 8'h45, 1'b1}, // R4 stays paused
        '{4'd5,  4'd2,  1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0}, // R5 above resume level
        '{4'd5,  4'd0,  1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0}, // R5 below resume level
        '{4'd2,  4'd1,  1'b0, 8'h00, 1'b1, 1'b1, 8'h11, 1'b0}, // R2 resume level is 1
        '{4'd2,  4'd11, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0}, // R2 11 below pause level
        '{4'd2,  4'd12, 1'b0, 8'h00, 1'b1, 1'b1, 8'h13, 1'b0}  // R2 pause level is 12
    };

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        rst = 1'b1; tb_valid = 0; tb_data = 0; ser_ready = 0;
        des_stb = 0; des_data = 0; rb_full = 0; rb_fill = 0;
        do_reset();

        // R1: reset state
        #1;
        check("R1", "rx_overflow", {7'd0, rx_overflow}, 8'd0);
        check("R10", "rb_put idle", {7'd0, rb_put}, 8'd0);

        // stimulus table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rb_fill   = VT[i].fill;
            tb_valid  = VT[i].valid;
            tb_data   = VT[i].data;
            ser_ready = VT[i].ready;
            #1;
            begin
                string tg;
                tg = $sformatf("R%0d[v%0d]", VT[i].req, i);
                check(tg, "ser_stb", {7'd0, ser_stb}, {7'd0, VT[i].e_stb});
                check(tg, "tb_got", {7'd0, tb_got}, {7'd0, VT[i].e_got});
                if (VT[i].e_stb)
                    check(tg, "ser_data", ser_data, VT[i].e_data);
            end
        end
        @(negedge clk);
        ser_ready = 0; tb_valid = 0; rb_fill = 4'd5;

        // R10: write-through when not full
        des_stb = 1; des_data = 8'hA5; rb_full = 0;
        #1;
        check("R10", "rb_put", {7'd0, rb_put}, 8'd1);
        check("R10", "rb_data", rb_data, 8'hA5);
        @(negedge clk);
        #1;
        check("R11", "no overflow after good write", {7'd0, rx_overflow}, 8'd0);

        // R10/R11: byte while full
        @(negedge clk);
        des_stb = 1; des_data = 8'h5A; rb_full = 1;
        #1;
        check("R10", "rb_put blocked when full", {7'd0, rb_put}, 8'd0);
        check("R11", "flag before edge", {7'd0, rx_overflow}, 8'd0);
        @(negedge clk);
        des_stb = 0; rb_full = 0;
        #1;
        check("R11", "flag set", {7'd0, rx_overflow}, 8'd1);
        for (int k = 0; k < 4; k++) @(negedge clk);
        #1;
        check("R11", "flag sticky", {7'd0, rx_overflow}, 8'd1);

        // R1: reset clears flag and re-enters paused state
        do_reset();
        #1;
        check("R1", "flag cleared by reset", {7'd0, rx_overflow}, 8'd0);
        @(negedge clk);
        rb_fill = 4'd1; ser_ready = 1;
        #1;
        check("R1", "XON after reset stb", {7'd0, ser_stb}, 8'd1);
        check("R1", "XON after reset data", ser_data, 8'h11);

        @(negedge clk);
        ser_ready = 0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule